// File: doc/BRIEF.md
# Lookahead-Address Synchronous RAM Wrapper

This wrapper lets a design built around a memory with an asynchronous read port run on a synchronous block RAM, which registers its read address, without adding a cycle of read latency. The client does not keep its own address register. It presents the value it would have loaded into that register (`nxt_addr`). The wrapper starts the RAM read with that value one cycle early. The result therefore appears in the same cycle in which an asynchronous memory, addressed by the registered address, would have produced it.

The write strobe is decoded late, in the access cycle itself. A write always lands at the registered address `cur_addr`, never at the next address. Since the read enable is not known in time, a read is started on every clock.

There are two variants, selected by `DUAL_PORT`:

- **Single-port (`DUAL_PORT=0`).** The RAM's own address register is the client's address register. A write deasserts its load enable, so the address latched in the previous cycle is kept.
- **Dual-port (`DUAL_PORT=1`).** One port reads continuously from the next address, and the other writes to the current address.

Top module: `lookahead_ram`

## Requirements
- R1: There is no read enable. A read happens every cycle: `rd_data` in the cycle after `nxt_addr`=A is presented and loaded equals the stored word at A, which is the contents at `cur_addr` as an asynchronous read would show them.
- R2: When `rst` is low and no write is signalled, `cur_addr` takes the value `nxt_addr` had before the clock edge.
- R3: With `wr_en` high in a cycle, `wr_data` is stored at `cur_addr` at the end of that cycle. During that cycle `rd_data` still shows the old contents.
- R4: With `DUAL_PORT=0`, a cycle with `wr_en` high leaves `cur_addr` unchanged, ignoring `nxt_addr`. In the next cycle `rd_data` shows the word just written.
- R5: With `DUAL_PORT=1`, `cur_addr` loads `nxt_addr` even in a write cycle. If that next address equals the address being written, the following cycle's `rd_data` is the new word, not the stale array output.
- R6: With `DUAL_PORT=1`, back-to-back write cycles store each word at the address registered in its own cycle.
- R7: A synchronous active-high `rst` sets `cur_addr` to 0 and blocks writes. After it, `rd_data` shows the word at address 0, and the stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nxt_addr | input | AW | Address to be registered at the next edge |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | DW | Word to store at `cur_addr` |
| cur_addr | output | AW | Registered address |
| rd_data | output | DW | Word stored at `cur_addr` |

## Verification
The bench builds two copies, with `DUAL_PORT` 0 and 1, both with `AW`=4 and `DW`=8. The 16-word array can therefore be filled completely before comparison starts, and random addresses hit the same word often. This brings read-after-write collisions, held addresses and reset-time reads of word 0 into frequent reach. Both copies run the same stimulus, and each is compared every cycle against its own asynchronous-read reference addressed by a modelled address register.

// File: rtl/lookahead_ram.sv
module lookahead_ram #(
  parameter int AW        = 10,
  parameter int DW        = 16,
  parameter bit DUAL_PORT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] nxt_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rd_q;
  logic          wr_go;
  logic [AW-1:0] rd_addr;

  assign wr_go    = wr_en & ~rst;
  assign cur_addr = addr_q;
  assign rd_data  = rd_q;

  generate
    if (DUAL_PORT) begin : g_dp
      assign rd_addr = rst ? '0 : nxt_addr;

      always_ff @(posedge clk) begin
        addr_q <= rd_addr;
        if (wr_go && rd_addr == addr_q) rd_q <= wr_data;
        else                            rd_q <= mem[rd_addr];
        if (wr_go) mem[addr_q] <= wr_data;
      end

      a_r5_dp_load: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cur_addr == $past(nxt_addr));
      a_r5_dp_forward: assert property (@(posedge clk) disable iff (rst)
        (wr_en && nxt_addr == cur_addr) |=> rd_data == $past(wr_data));
    end else begin : g_sp
      assign rd_addr = rst ? '0 : (wr_go ? addr_q : nxt_addr);

      always_ff @(posedge clk) begin
        if (wr_go) begin
          mem[addr_q] <= wr_data;
          rd_q        <= wr_data;
        end else begin
          addr_q <= rd_addr;
          rd_q   <= mem[rd_addr];
        end
      end

      a_r4_sp_hold: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cur_addr == $past(cur_addr));
      a_r4_sp_new_word: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == $past(wr_data));
      a_r2_sp_load: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> cur_addr == $past(nxt_addr));
    end
  endgenerate

  a_r7_reset_addr: assert property (@(posedge clk)
    rst |=> cur_addr == '0);
endmodule

// File: tb/lookahead_ram_bench.sv
module lookahead_ram_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NV = 20;

  // vector: {addr[3:0], wr, data[7:0]}
  localparam logic [12:0] VEC [NV] = '{
    {4'd3, 1'b0, 8'h00}, {4'd7, 1'b0, 8'h00}, {4'd7, 1'b1, 8'hA5},
    {4'd7, 1'b0, 8'h00}, {4'd2, 1'b0, 8'h00}, {4'd9, 1'b1, 8'h3C},
    {4'd10,1'b1, 8'h4D}, {4'd11,1'b1, 8'h5E}, {4'd11,1'b0, 8'h00},
    {4'd10,1'b0, 8'h00}, {4'd9, 1'b0, 8'h00}, {4'd0, 1'b0, 8'h00},
    {4'd15,1'b0, 8'h00}, {4'd15,1'b1, 8'h99}, {4'd15,1'b1, 8'h77},
    {4'd15,1'b0, 8'h00}, {4'd1, 1'b0, 8'h00}, {4'd1, 1'b1, 8'hEE},
    {4'd4, 1'b0, 8'h00}, {4'd1, 1'b0, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] nxt = '0;
  logic          wr  = 1'b0;
  logic [DW-1:0] wd  = '0;
  logic [AW-1:0] ca0, ca1;
  logic [DW-1:0] rd0, rd1;

  int errors = 0;
  int checks = 0;
  bit armed  = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lookahead_ram #(.AW(AW), .DW(DW), .DUAL_PORT(1'b0)) u_lookahead_ram (
    .clk(clk), .rst(rst), .nxt_addr(nxt), .wr_en(wr), .wr_data(wd),
    .cur_addr(ca0), .rd_data(rd0));

  lookahead_ram #(.AW(AW), .DW(DW), .DUAL_PORT(1'b1)) u_lookahead_ram_dp (
    .clk(clk), .rst(rst), .nxt_addr(nxt), .wr_en(wr), .wr_data(wd),
    .cur_addr(ca1), .rd_data(rd1));

  logic [AW-1:0] ref_a0, ref_a1;
  logic [DW-1:0] ref_m0 [1<<AW];
  logic [DW-1:0] ref_m1 [1<<AW];

  always @(posedge clk) begin
    if (rst)      ref_a0 <= '0;
    else if (!wr) ref_a0 <= nxt;
    if (rst) ref_a1 <= '0;
    else     ref_a1 <= nxt;
    if (wr && !rst) begin
      ref_m0[ref_a0] <= wd;
      ref_m1[ref_a1] <= wd;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic [AW-1:0] a,
                      input logic w, input logic [DW-1:0] d);
    @(negedge clk);
    if (armed) begin
      chk(tag, "sp cur_addr", int'(ca0), int'(ref_a0));
      chk(tag, "sp rd_data",  int'(rd0), int'(ref_m0[ref_a0]));
      chk(tag, "dp cur_addr", int'(ca1), int'(ref_a1));
      chk(tag, "dp rd_data",  int'(rd1), int'(ref_m1[ref_a1]));
    end
    rst = r; nxt = a; wr = w; wd = d;
  endtask

  initial begin
    step("R7", 1'b1, '0, 1'b0, '0);
    step("R7", 1'b1, '0, 1'b0, '0);
    for (int k = 0; k < (1 << AW); k++) begin
      step("R3", 1'b0, AW'(k), 1'b0, '0);
      step("R3", 1'b0, AW'(k), 1'b1, DW'(k * 7 + 3));
    end
    step("R1", 1'b0, 4'd0, 1'b0, '0);
    step("R1", 1'b0, 4'd0, 1'b0, '0);
    armed = 1'b1;
    // R1 R3 R4 R5 R6: table walk covers reads, held address, forwarding, back-to-back writes
    for (int i = 0; i < NV; i++)
      step("R1/R3/R4/R5/R6", 1'b0, VEC[i][12:9], VEC[i][8], VEC[i][7:0]);
    step("R3", 1'b0, 4'd8, 1'b0, '0);
    // R3: write cycle shows old word
    step("R3", 1'b0, 4'd8, 1'b1, 8'h42);
    step("R3", 1'b0, 4'd8, 1'b0, '0);
    // R5: dual port writes 8 while next address is also 8
    step("R5", 1'b0, 4'd8, 1'b1, 8'h24);
    step("R5", 1'b0, 4'd6, 1'b0, '0);
    for (int i = 0; i < 400; i++)
      step("R2", 1'b0, AW'($urandom), ($urandom % 4) == 0, DW'($urandom));
    step("R6", 1'b0, 4'd12, 1'b1, 8'h11);
    step("R6", 1'b0, 4'd13, 1'b1, 8'h22);
    step("R6", 1'b0, 4'd14, 1'b1, 8'h33);
    step("R6", 1'b0, 4'd12, 1'b0, '0);
    step("R6", 1'b0, 4'd13, 1'b0, '0);
    // R7: reset with write strobe high must not write and must point at word 0
    step("R7", 1'b1, 4'd9, 1'b1, 8'hFF);
    step("R7", 1'b0, 4'd9, 1'b0, '0);
    step("R7", 1'b0, 4'd9, 1'b0, '0);
    @(negedge clk);
    chk("R7", "sp word 9 kept", int'(rd0), int'(ref_m0[4'd9]));
    chk("R7", "dp word 9 kept", int'(rd1), int'(ref_m1[4'd9]));
    step("R1", 1'b0, '0, 1'b0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule